// File: doc/BRIEF.md
# Selectable-Source Module Clock Divider

This block derives one module clock from a bank of parent clock sources. The parent sources arrive as single-cycle tick strobes that share one fast reference clock, so the whole block stays in one clock domain. One 32-bit control word sets four things: which parent is used, a power-of-two prescale, an integer divide ratio from 1 to 16, and an output gate. The output level stays at a fixed divided rate and changes only at moments set by the chosen parent.

Software writes the control word in one cycle and can read it back in the same cycle. New divide settings take effect only when an output period ends, so no short pulse appears. A change of parent waits until the current high phase has finished, holds the output low, and counts a few ticks of the new parent before the divider restarts. One build variant keeps the gate open at all times, whatever is written to it. A second parameter sets how wide the parent-select field is.

Top module: `modclk_div`

## Requirements
- R1: After reset the control word reads 0x00000000 and the output is low. The always-on variant reads 0x80000000 instead.
- R2: Field positions are: divide field D at bits 3:0, prescale field S at bits 17:16, parent select at bits 24 upward (SEL_W bits wide), and gate bit 31. All other bits read as zero, and a write takes effect from the next clock.
- R3: While the block runs, the output period is (D+1)·2^S ticks of the selected parent.
- R4: In each period the output is high for floor((D+1)/2)·2^S parent ticks, with the high phase first. When D=0 the output stays high for as long as the block runs.
- R5: When the gate bit is clear, the output is low from the second clock after the write and stays low.
- R6: A new D or S written in the middle of a period does not change the period in progress. It applies from the next period boundary.
- R7: The output rises only in the cycle after a selected-parent tick, and only at a period boundary, so it never runs faster than its parent.
- R8: On a change of parent select, a high phase already under way completes at full width. The output is then held low until SYNC_TICKS ticks of the new parent have been seen, and the divider restarts from a fresh period.
- R9: With ALWAYS_ON set, writes cannot clear the gate bit: it reads back as 1 and the output keeps toggling.
- R10: The select field is SEL_W bits wide and chooses among 2^SEL_W parent sources. Each source is counted at its own tick rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value, unused bits zero |
| src_tick | input | 2^SEL_W | One tick strobe per parent source |
| mod_clk | output | 1 | Divided, gated module clock level |

## Verification
The bench builds two instances. The first uses SEL_W=3 with the gate writable, so eight parents with tick spacings of 1 to 4 clocks are selectable. This lets period and high-time measurements tell the parents apart and exercises the upper select bits. The second uses SEL_W=2 with ALWAYS_ON=1, which is the only way to see a gate write being refused. SYNC_TICKS stays at 2, so a parent switch finishes quickly enough to measure the periods that follow it.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  localparam int DIV_LSB = 0;
  localparam int DIV_W   = 4;
  localparam int PRE_LSB = 16;
  localparam int PRE_W   = 2;
  localparam int SEL_LSB = 24;
  localparam int GATE_BIT = 31;

  typedef enum logic {SW_RUN = 1'b0, SW_SYNC = 1'b1} sw_state_e;

  // Number of prescaled cycles the output stays high in one period.
  function automatic logic [DIV_W:0] high_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] n;
    n = {1'b0, d} + 1'b1;
    if (d == '0) return 1;
    return n >> 1;
  endfunction

  // Last count value of the power-of-two prescaler.
  function automatic logic [2:0] pre_last(input logic [PRE_W-1:0] s);
    return 3'((4'd1 << s) - 4'd1);
  endfunction

endpackage

// File: rtl/modclk_regs.sv
module modclk_regs
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              gate_q,
  output logic [31:0]       rd_data
);

  logic unused_wd;
  assign unused_wd = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      pre_q  <= '0;
      sel_q  <= '0;
      gate_q <= ALWAYS_ON;
    end else if (wr_en) begin
      div_q  <= wr_data[DIV_LSB +: DIV_W];
      pre_q  <= wr_data[PRE_LSB +: PRE_W];
      sel_q  <= wr_data[SEL_LSB +: SEL_W];
      gate_q <= ALWAYS_ON ? 1'b1 : wr_data[GATE_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[DIV_LSB +: DIV_W] = div_q;
    rd_data[PRE_LSB +: PRE_W] = pre_q;
    rd_data[SEL_LSB +: SEL_W] = sel_q;
    rd_data[GATE_BIT]         = gate_q;
  end

endmodule

// File: rtl/modclk_srcsel.sv
module modclk_srcsel
  import modclk_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int SYNC_TICKS = 2,
  localparam int NSRC      = 1 << SEL_W,
  localparam int CW        = $clog2(SYNC_TICKS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             out_level,
  output logic             act_tick,
  output logic             park,
  output logic             running
);

  sw_state_e        state;
  logic [SEL_W-1:0] cur_sel;
  logic [CW-1:0]    sync_cnt;

  assign act_tick = src_tick[cur_sel];
  assign running  = (state == SW_RUN);
  assign park     = running && (sel_req != cur_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SW_RUN;
      cur_sel  <= '0;
      sync_cnt <= '0;
    end else begin
      case (state)
        SW_RUN: begin
          if (park && !out_level) begin
            state    <= SW_SYNC;
            cur_sel  <= sel_req;
            sync_cnt <= '0;
          end
        end
        SW_SYNC: begin
          if (sel_req != cur_sel) begin
            cur_sel  <= sel_req;
            sync_cnt <= '0;
          end else if (act_tick) begin
            if (sync_cnt == CW'(SYNC_TICKS - 1)) begin
              state    <= SW_RUN;
              sync_cnt <= '0;
            end else begin
              sync_cnt <= sync_cnt + 1'b1;
            end
          end
        end
        default: state <= SW_RUN;
      endcase
    end
  end

endmodule

// File: rtl/modclk_divcore.sv
module modclk_divcore
  import modclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             park,
  input  logic [DIV_W-1:0] div_req,
  input  logic [PRE_W-1:0] pre_req,
  output logic             clk_out,
  output logic             period_start,
  output logic             active,
  output logic [DIV_W-1:0] div_act
);

  logic [2:0]       pre_cnt;
  logic [DIV_W-1:0] pos;
  logic [PRE_W-1:0] pre_act;
  logic             fresh;
  logic             out_q;
  logic             pre_wrap;
  logic             ptick;
  logic [DIV_W:0]   pos_next;

  assign active       = run && !(park && (!out_q || div_act == '0));
  assign pre_wrap     = (pre_cnt == pre_last(pre_act));
  assign ptick        = active && tick && pre_wrap;
  assign period_start = ptick && (fresh || pos == div_act);
  assign pos_next     = {1'b0, pos} + 1'b1;
  assign clk_out      = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pos     <= '0;
      pre_act <= '0;
      div_act <= '0;
      fresh   <= 1'b1;
      out_q   <= 1'b0;
    end else if (!active) begin
      pre_cnt <= '0;
      pos     <= '0;
      fresh   <= 1'b1;
      out_q   <= 1'b0;
      div_act <= div_req;
      pre_act <= pre_req;
    end else if (tick) begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        if (period_start) begin
          pos     <= '0;
          fresh   <= 1'b0;
          div_act <= div_req;
          pre_act <= pre_req;
          out_q   <= 1'b1;
        end else begin
          pos   <= pos_next[DIV_W-1:0];
          out_q <= (pos_next < high_len(div_act));
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/modclk_div.sv
module modclk_div
  import modclk_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter bit ALWAYS_ON  = 1'b0,
  parameter int SYNC_TICKS = 2,
  localparam int NSRC      = 1 << SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NSRC-1:0] src_tick,
  output logic            mod_clk
);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] sel_q;
  logic             gate_q;
  logic             act_tick;
  logic             park;
  logic             running;
  logic             run;
  logic             period_start;
  logic             div_active;
  logic [DIV_W-1:0] div_act;

  modclk_regs #(.SEL_W(SEL_W), .ALWAYS_ON(ALWAYS_ON)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_q(div_q), .pre_q(pre_q), .sel_q(sel_q), .gate_q(gate_q),
    .rd_data(rd_data)
  );

  modclk_srcsel #(.SEL_W(SEL_W), .SYNC_TICKS(SYNC_TICKS)) srcsel_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel_req(sel_q),
    .out_level(mod_clk), .act_tick(act_tick), .park(park),
    .running(running)
  );

  assign run = gate_q && running;

  modclk_divcore divcore_i (
    .clk(clk), .rst_n(rst_n), .tick(act_tick), .run(run), .park(park),
    .div_req(div_q), .pre_req(pre_q), .clk_out(mod_clk),
    .period_start(period_start), .active(div_active), .div_act(div_act)
  );

endmodule

// File: rtl/modclk_div_chk.sv
module modclk_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_q,
  input logic       running,
  input logic       act_tick,
  input logic       mod_clk,
  input logic       period_start,
  input logic       div_active,
  input logic [3:0] div_act
);

  p_gate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> !mod_clk);

  p_rise_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_clk) |-> $past(act_tick));

  p_rise_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_clk) |-> $past(period_start));

  p_park_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mod_clk);

  p_boundary_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> $past(period_start || !div_active));

endmodule

bind modclk_div modclk_div_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .running(running),
  .act_tick(act_tick), .mod_clk(mod_clk), .period_start(period_start),
  .div_active(div_active), .div_act(div_act)
);

// File: tb/modclk_div_tb_top.sv
module modclk_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_a, wr_b;
  logic [31:0] wd_a, wd_b, rd_a, rd_b;
  logic [7:0]  ticks;
  logic        mod_a, mod_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  modclk_div #(.SEL_W(3), .ALWAYS_ON(1'b0), .SYNC_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_data(wd_a), .rd_data(rd_a),
    .src_tick(ticks), .mod_clk(mod_a)
  );

  modclk_div #(.SEL_W(2), .ALWAYS_ON(1'b1), .SYNC_TICKS(2)) aon_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_data(wd_b), .rd_data(rd_b),
    .src_tick(ticks[3:0]), .mod_clk(mod_b)
  );

  function automatic int k_of(input int s);
    return (s % 4) + 1;
  endfunction

  function automatic int exp_per(input int d, input int s, input int src);
    return (d + 1) * (1 << s) * k_of(src);
  endfunction

  function automatic int exp_hi(input int d, input int s, input int src);
    int h;
    h = (d == 0) ? 1 : (d + 1) / 2;
    return h * (1 << s) * k_of(src);
  endfunction

  function automatic logic [31:0] word(input bit g, input int src, input int s, input int d);
    return {g, 3'b000, 4'(src), 6'b0, 2'(s), 12'b0, 4'(d)};
  endfunction

  function automatic logic [31:0] rd_mask(input int selw);
    return 32'h8000_0000 | (((32'd1 << selw) - 32'd1) << 24) | 32'h0003_000F;
  endfunction

  initial begin
    int cyc = 0;
    ticks = '0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 8; i++) ticks[i] = ((cyc % k_of(i)) == 0);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [31:0] d);
    @(negedge clk);
    if (b) begin wr_b = 1'b1; wd_b = d; end
    else   begin wr_a = 1'b1; wd_a = d; end
    @(negedge clk);
    wr_a = 1'b0;
    wr_b = 1'b0;
  endtask

  function automatic logic getm(input bit b);
    return b ? mod_b : mod_a;
  endfunction

  task automatic wait_rise(input bit b, output bit ok);
    logic pr;
    int n = 0;
    ok = 1'b0;
    @(negedge clk);
    pr = getm(b);
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (!pr && getm(b)) begin ok = 1'b1; break; end
      pr = getm(b);
    end
  endtask

  task automatic meas_cont(input bit b, output int per, output int hi);
    logic pr = 1'b1;
    logic cu;
    per = 0;
    hi  = 1;
    while (per < 4000) begin
      @(negedge clk);
      per++;
      cu = getm(b);
      if (!pr && cu) break;
      if (cu) hi++;
      pr = cu;
    end
  endtask

  task automatic measure(input bit b, output int per, output int hi);
    bit ok;
    wait_rise(b, ok);
    if (!ok) begin per = -1; hi = -1; end
    else meas_cont(b, per, hi);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int per, hi, per1, hi1, highs;
    rst_n = 1'b0;
    wr_a = 1'b0; wr_b = 1'b0; wd_a = '0; wd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_a == 32'h0, "R1 reset word", rd_a, 0);
    check(mod_a == 1'b0, "R1 reset output", mod_a, 0);
    check(rd_b == 32'h8000_0000, "R1 always-on reset word", rd_b, 32'h8000_0000);

    // R2 readback masks unused bits
    wr(0, 32'hFFFF_FFFF);
    check(rd_a == rd_mask(3), "R2 readback mask", rd_a, rd_mask(3));
    wr(0, 32'h0);
    check(rd_a == 32'h0, "R2 readback clear", rd_a, 0);

    // R3 R4 odd ratio
    wr(0, word(1, 0, 0, 4));
    measure(0, per, hi);
    measure(0, per, hi);
    check(per == exp_per(4, 0, 0), "R3 period D=4", per, exp_per(4, 0, 0));
    check(hi == exp_hi(4, 0, 0), "R4 high D=4", hi, exp_hi(4, 0, 0));

    // R4 D=0 steady high
    wr(0, word(1, 0, 0, 0));
    repeat (12) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mod_a) highs++; end
    check(highs == 20, "R4 D=0 steady high", highs, 20);

    // R6 mid-period change
    wr(0, word(1, 0, 0, 3));
    measure(0, per, hi);
    begin
      bit ok;
      wait_rise(0, ok);
    end
    fork
      meas_cont(0, per1, hi1);
      wr(0, word(1, 0, 1, 7));
    join
    check(per1 == 4 && hi1 == 2, "R6 period in progress", per1 * 100 + hi1, 402);
    measure(0, per, hi);
    check(per == exp_per(7, 1, 0), "R6 new period", per, exp_per(7, 1, 0));
    check(hi == exp_hi(7, 1, 0), "R6 new high", hi, exp_hi(7, 1, 0));

    // R8 parent switch
    wr(0, word(1, 0, 1, 3));
    measure(0, per, hi);
    begin
      bit ok;
      wait_rise(0, ok);
    end
    fork
      meas_cont(0, per1, hi1);
      wr(0, word(1, 3, 1, 3));
    join
    check(hi1 == exp_hi(3, 1, 0), "R8 high completes", hi1, exp_hi(3, 1, 0));
    measure(0, per, hi);
    check(per == exp_per(3, 1, 3), "R8 period on new parent", per, exp_per(3, 1, 3));
    check(hi == exp_hi(3, 1, 3), "R8 high on new parent", hi, exp_hi(3, 1, 3));

    // R7 R10 sparse parent in upper select range
    wr(0, word(1, 6, 0, 1));
    measure(0, per, hi);
    measure(0, per, hi);
    check(per == exp_per(1, 0, 6), "R7 R10 sparse parent period", per, exp_per(1, 0, 6));
    check(hi == exp_hi(1, 0, 6), "R10 sparse parent high", hi, exp_hi(1, 0, 6));

    // R5 gate
    wr(0, word(0, 6, 0, 1));
    check(rd_a[31] == 1'b0, "R5 gate bit reads clear", rd_a[31], 0);
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (mod_a) highs++; end
    check(highs == 0, "R5 gated output low", highs, 0);

    // R9 always-on refuses gate clear
    wr(1, 32'h0000_0001);
    check(rd_b == 32'h8000_0001, "R9 gate stays set", rd_b, 32'h8000_0001);
    measure(1, per, hi);
    measure(1, per, hi);
    check(per == 2 && hi == 1, "R9 output keeps toggling", per * 100 + hi, 201);

    // Random configurations, R3 R4 R10
    begin
      void'($urandom(32'd1234));
      for (int it = 0; it < 12; it++) begin
        int d, s, src;
        d   = 1 + int'($urandom % 15);
        s   = int'($urandom % 4);
        src = int'($urandom % 8);
        wr(0, word(1, src, s, d));
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == exp_per(d, s, src), "R3 random period", per, exp_per(d, s, src));
        check(hi == exp_hi(d, s, src), "R4 random high", hi, exp_hi(d, s, src));
      end
    end

    finish_run();
  end

endmodule